// File: doc/BRIEF.md
# I/O Page Open-Bus Read Merger

This block stands for the CPU data bus of an 8-bit console at its I/O page. A register keeps the last value that any completed bus cycle left on the data bus. When the CPU reads one of the three I/O registers the block serves, only the bits that a device really drives come from that device. Every other bit comes back as the held bus value, which is how a bus with no driver behaves. An address the block does not serve returns the held value on all eight bits.

Two console variants use different bit maps for the controller ports, and a mode input selects between them. A preload input lets the bench model the operand fetch cycles that come before an I/O access. On the real bus such a fetch leaves the high address byte, $40, on the data lines.

Top module: `cpu_io_bus_merge`

## Requirements
- R1: After reset the held bus value is $00, so a read of an unserved address returns $00.
- R2: A write cycle (`cyc_en`=1, `is_read`=0) loads `wdata` into the held bus value. A clock with no cycle and no preload leaves the held value unchanged.
- R3: A read cycle loads the complete composed `rd_data` into the held bus value.
- R4: With `variant_b`=0, address $4016 reads bit0=`pad1_ser`, bit1=`exp1_in[0]`, bit2=`mic_in`. Bits 7:3 come from the held bus.
- R5: Address $4017 reads bit0=`pad2_ser` and bits 4:1=`exp2_in[3:0]` in both variants. Bits 7:5 come from the held bus.
- R6: With `variant_b`=1, address $4016 reads bit0=`pad1_ser` and bits 4:1=`exp1_in[3:0]`. Bits 7:5 come from the held bus.
- R7: Address $4015 reads bits 4:0=`apu_stat[4:0]` and bits 7:6=`apu_stat[6:5]`. Bit 5 comes from the held bus.
- R8: Every other address returns all eight bits from the held bus.
- R9: With `preload_en`=1 and no cycle, the held value takes `preload_val` at the clock edge. A read in the same clock takes its open bits from `preload_val` rather than the held value. A write in the same clock wins over the preload.
- R10: After a preload of $40, a read of $4016 in either variant returns $40 in its undriven upper bits, merged with the driven low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_b | input | 1 | Selects the console variant bit map (0 = A, 1 = B) |
| cyc_en | input | 1 | A bus cycle completes at this clock edge |
| is_read | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| pad1_ser | input | 1 | Serial data from controller port 1 |
| pad2_ser | input | 1 | Serial data from controller port 2 |
| mic_in | input | 1 | Microphone level (variant A, port 1 bit 2) |
| exp1_in | input | 4 | Expansion lines for port 1, bits 4:1 (tie to 0 when unused) |
| exp2_in | input | 4 | Expansion lines for port 2, bits 4:1 (tie to 0 when unused) |
| apu_stat | input | 7 | Audio status flags for the seven implemented bits |
| preload_en | input | 1 | Place `preload_val` on the bus (operand fetch model) |
| preload_val | input | 8 | Value for the preload |
| rd_data | output | 8 | Composed read data |

## Verification
Two of the block's functions can fall in the same cycle: a preload and a bus cycle. The bench drives `preload_en` on its own, together with reads and together with writes, under both directed and random stimulus. The reference model applies the rule on its own terms. In a read, the open bits take the preload value, and the held register then captures the merged word. In a write, the write data ends up in the held register. The design's `rd_data` is compared with the model on every clock, and the held state is observed through later reads of unserved addresses.

// File: rtl/cpu_io_bus_merge.sv
module cpu_io_bus_merge #(
  parameter int AW = 16,
  parameter logic [AW-1:0] STAT_ADDR  = 16'h4015,
  parameter logic [AW-1:0] PORT1_ADDR = 16'h4016,
  parameter logic [AW-1:0] PORT2_ADDR = 16'h4017
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          variant_b,
  input  logic          cyc_en,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          pad1_ser,
  input  logic          pad2_ser,
  input  logic          mic_in,
  input  logic [3:0]    exp1_in,
  input  logic [3:0]    exp2_in,
  input  logic [6:0]    apu_stat,
  input  logic          preload_en,
  input  logic [7:0]    preload_val,
  output logic [7:0]    rd_data
);

  logic [7:0] bus_q, bus_eff, drv, mask;

  assign bus_eff = preload_en ? preload_val : bus_q;

  always_comb begin
    drv  = '0;
    mask = '0;
    if (addr == STAT_ADDR) begin
      mask = 8'hDF;
      drv  = {apu_stat[6:5], 1'b0, apu_stat[4:0]};
    end else if (addr == PORT1_ADDR) begin
      if (variant_b) begin
        mask = 8'h1F;
        drv  = {3'b000, exp1_in, pad1_ser};
      end else begin
        mask = 8'h07;
        drv  = {5'b00000, mic_in, exp1_in[0], pad1_ser};
      end
    end else if (addr == PORT2_ADDR) begin
      mask = 8'h1F;
      drv  = {3'b000, exp2_in, pad2_ser};
    end
  end

  assign rd_data = (drv & mask) | (bus_eff & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n)          bus_q <= 8'h00;
    else if (cyc_en)     bus_q <= is_read ? rd_data : wdata;
    else if (preload_en) bus_q <= preload_val;
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !is_read) |=> (bus_q == $past(wdata)));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !preload_en) |=> $stable(bus_q));

  p_read_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && is_read) |=> (bus_q == $past(rd_data)));

  p_port1a_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && is_read && !preload_en && !variant_b && addr == PORT1_ADDR)
      |=> (bus_q[7:3] == $past(bus_q[7:3])));

  p_port2_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && is_read && !preload_en && addr == PORT2_ADDR)
      |=> (bus_q[7:5] == $past(bus_q[7:5])));

  p_stat_bit5_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && is_read && !preload_en && addr == STAT_ADDR)
      |=> (bus_q[5] == $past(bus_q[5])));

  p_preload_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && preload_en) |=> (bus_q == $past(preload_val)));

endmodule

// File: tb/test_cpu_io_bus_merge.sv
module test_cpu_io_bus_merge;
  logic clk = 0, rst_n = 0;
  logic variant_b = 0, cyc_en = 0, is_read = 0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = 0, preload_val = 0;
  logic pad1_ser = 0, pad2_ser = 0, mic_in = 0, preload_en = 0;
  logic [3:0] exp1_in = 0, exp2_in = 0;
  logic [6:0] apu_stat = 0;
  logic [7:0] rd_data;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] m_bus = 8'h00;

  always #4 clk = ~clk;

  cpu_io_bus_merge i_cpu_io_bus_merge (
    .clk(clk), .rst_n(rst_n), .variant_b(variant_b), .cyc_en(cyc_en),
    .is_read(is_read), .addr(addr), .wdata(wdata), .pad1_ser(pad1_ser),
    .pad2_ser(pad2_ser), .mic_in(mic_in), .exp1_in(exp1_in), .exp2_in(exp2_in),
    .apu_stat(apu_stat), .preload_en(preload_en), .preload_val(preload_val),
    .rd_data(rd_data));

  function automatic logic [7:0] model_read();
    logic [7:0] v;
    v = preload_en ? preload_val : m_bus;
    case (addr)
      16'h4015: begin
        for (int b = 0; b < 5; b++) v[b] = apu_stat[b];
        v[6] = apu_stat[5];
        v[7] = apu_stat[6];
      end
      16'h4016: begin
        v[0] = pad1_ser;
        v[1] = exp1_in[0];
        if (variant_b) begin
          v[2] = exp1_in[1]; v[3] = exp1_in[2]; v[4] = exp1_in[3];
        end else v[2] = mic_in;
      end
      16'h4017: begin
        v[0] = pad2_ser;
        for (int b = 0; b < 4; b++) v[b+1] = exp2_in[b];
      end
      default: ;
    endcase
    return v;
  endfunction

  task automatic check(input string tag);
    logic [7:0] exp;
    #1;
    exp = model_read();
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h vb=%0d got=%h exp=%h", tag, addr, variant_b, rd_data, exp);
    end
    @(posedge clk);
    if (cyc_en) m_bus = is_read ? exp : wdata;
    else if (preload_en) m_bus = preload_val;
    @(negedge clk);
  endtask

  task automatic op(input string tag, input logic c, input logic r, input logic [15:0] a,
                    input logic [7:0] d, input logic pe, input logic [7:0] pv);
    cyc_en = c; is_read = r; addr = a; wdata = d; preload_en = pe; preload_val = pv;
    check(tag);
  endtask

  initial begin
    #(8*200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    op("R1 reset", 0, 1, 16'h5000, 8'h00, 0, 8'h00);
    op("R2 write", 1, 0, 16'h2000, 8'hA5, 0, 8'h00);
    op("R2 hold", 0, 1, 16'h8000, 8'h00, 0, 8'h00);
    op("R2 hold", 0, 1, 16'h4018, 8'h00, 0, 8'h00);
    pad1_ser = 1; mic_in = 1; exp1_in = 4'b1011;
    op("R4 vA 4016", 1, 1, 16'h4016, 8'h00, 0, 8'h00);
    op("R3 lands", 0, 1, 16'hFFFF, 8'h00, 0, 8'h00);
    pad2_ser = 1; exp2_in = 4'b0110;
    op("R5 4017", 1, 0, 16'h4017, 8'hFF, 0, 8'h00);
    op("R5 4017", 1, 1, 16'h4017, 8'h00, 0, 8'h00);
    variant_b = 1;
    op("R6 vB 4016", 1, 1, 16'h4016, 8'h00, 0, 8'h00);
    op("R5 vB 4017", 1, 1, 16'h4017, 8'h00, 0, 8'h00);
    apu_stat = 7'b1010101;
    op("R2 write", 1, 0, 16'h4015, 8'h20, 0, 8'h00);
    op("R7 4015", 1, 1, 16'h4015, 8'h00, 0, 8'h00);
    op("R8 other", 1, 1, 16'h4014, 8'h00, 0, 8'h00);
    op("R9 preload", 0, 1, 16'h6000, 8'h00, 1, 8'h3C);
    op("R9 held", 0, 1, 16'h6000, 8'h00, 0, 8'h00);
    op("R9 write wins", 1, 0, 16'h6000, 8'h81, 1, 8'h7E);
    op("R9 held", 0, 1, 16'h6000, 8'h00, 0, 8'h00);
    exp1_in = 4'b0000;
    op("R10 vB fetch", 1, 1, 16'h4016, 8'h00, 1, 8'h40);
    op("R10 lands", 0, 1, 16'h9000, 8'h00, 0, 8'h00);
    variant_b = 0;
    op("R10 vA fetch", 1, 1, 16'h4016, 8'h00, 1, 8'h40);
    op("R10 lands", 0, 1, 16'h9000, 8'h00, 0, 8'h00);
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 4))
        0: a = 16'h4015;
        1: a = 16'h4016;
        2: a = 16'h4017;
        default: a = 16'($urandom);
      endcase
      variant_b = 1'($urandom);
      pad1_ser = 1'($urandom); pad2_ser = 1'($urandom); mic_in = 1'($urandom);
      exp1_in = 4'($urandom); exp2_in = 4'($urandom); apu_stat = 7'($urandom);
      op("R3 random", 1'($urandom), 1'($urandom), a, 8'($urandom),
         ($urandom_range(0, 3) == 0), 8'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule